// File: doc/BRIEF.md
# CSR Access Legality Checker

This combinational unit decides, for one control and status register (CSR) access, whether the access must raise an illegal-instruction trap. It sits beside the CSR file of a small RISC-V style core. The inputs are the 12-bit CSR address, the current privilege level, a write-intent flag and a few pieces of machine state: the floating-point unit state field, the two counter-enable masks, the supervisor-mode present bit and a configuration bit that says whether physical memory protection exists.

A lookup sorts each address into one class: floating-point, user counter, machine, supervisor, protection, or unmapped. Each class has its own existence predicate. That predicate is combined with two address-based checks. The first is the minimum privilege held in address bits [9:8]. The second is the read-only space marked by bits [11:10] = 2'b11. The result is a single trap flag. A second flag marks the performance counters and event selectors that this core does not implement. Software reads those as zero. The unit stores no CSR state and carries no read or write data.

Both outputs follow the inputs in the same cycle. The pipeline samples them at the stage where the CSR instruction is decoded.

Top module: `csr_legality_check`

## Requirements
- R1: The floating-point CSRs 0x001, 0x002 and 0x003 are illegal whenever the FS input equals 2'b00. With any other FS value they pass the predicate at every privilege.
- R2: The user counter CSRs are 0xC00 to 0xC1F, plus 0xC80 to 0xC9F when RV32 = 1. Each is gated by bit addr[4:0] of an enable mask. At privilege U (2'b00) the mask is `scounteren_i`. At S (2'b01) it is `mcounteren_i`. At M (2'b11) every bit counts as set. A clear bit makes the access illegal.
- R3: The supervisor CSRs are illegal while `misa_s_i` is low: 0x100, 0x104, 0x105, 0x106, 0x140 to 0x144 and 0x180.
- R4: The protection CSRs are illegal while `pmp_en_i` is low. These are the configuration registers 0x3A0 to 0x3A3 (even indices only when RV32 = 0) and the address registers 0x3B0 to 0x3BF (with 16 entries).
- R5: The machine CSRs always pass the predicate. These are 0x300 to 0x306, 0x340 to 0x344, 0xF11 to 0xF14, 0xB00, 0xB02, 0xB03 to 0xB1F, 0x323 to 0x33F, and with RV32 = 1 also 0xB80, 0xB82 and 0xB83 to 0xB9F.
- R6: Every address outside the classes above is illegal. This includes 0xB01 and 0xB81.
- R7: An access is illegal when the privilege code is numerically below address bits [9:8].
- R8: A write (`wr_i` = 1) to an address with bits [11:10] = 2'b11 is illegal even when every other check passes. A read of the same address is unaffected.
- R9: `raz_o` is high exactly for legal accesses to 0xB03 to 0xB1F, 0xB83 to 0xB9F, 0x323 to 0x33F, 0xC03 to 0xC1F and 0xC83 to 0xC9F. `raz_o` and `illegal_o` are never high together.
- R10: Both outputs depend only on the present inputs and settle without any clock edge.
- R11: The reserved privilege code 2'b10 makes every access illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| csr_addr_i | input | 12 | CSR address of the access |
| priv_i | input | 2 | Current privilege: 2'b00 U, 2'b01 S, 2'b11 M |
| wr_i | input | 1 | Access intends to write the CSR |
| fs_i | input | 2 | Floating-point unit state field; 2'b00 means off |
| mcounteren_i | input | 32 | Counter-enable mask applied at privilege S |
| scounteren_i | input | 32 | Counter-enable mask applied at privilege U |
| misa_s_i | input | 1 | Supervisor mode is implemented |
| pmp_en_i | input | 1 | Physical memory protection is implemented |
| illegal_o | output | 1 | Access must raise an illegal-instruction trap |
| raz_o | output | 1 | Legal access to an unimplemented counter; reads return zero |

## Verification
The assertions sample the outputs only after the inputs have settled. They therefore assume that all inputs are driven to defined values and hold steady until the outputs are read. The bench meets this by changing every input at once and then waiting before it samples. The assertions also assume that the privilege code 2'b10 never appears in normal operation, and the sweeps use only U, S and M. The reserved code is applied only in a single directed vector, and the design maps it to a trap, so the assertions still hold there.

// File: rtl/csr_chk_pkg.sv
// Package: shared types for the CSR legality checker.
// Assumes privilege codes follow the 2-bit U/S/M encoding used by the core.
package csr_chk_pkg;

    localparam logic [1:0] PRIV_U = 2'b00;
    localparam logic [1:0] PRIV_S = 2'b01;
    localparam logic [1:0] PRIV_R = 2'b10;
    localparam logic [1:0] PRIV_M = 2'b11;

    // Predicate class chosen by the address lookup.
    typedef enum logic [2:0] {
        CLS_NONE = 3'd0,
        CLS_FP   = 3'd1,
        CLS_UCTR = 3'd2,
        CLS_MACH = 3'd3,
        CLS_SUP  = 3'd4,
        CLS_PMP  = 3'd5
    } csr_cls_e;

    // Decoder result: class plus "unimplemented counter" marker.
    typedef struct packed {
        csr_cls_e cls;
        logic     raz;
    } csr_dec_t;

endpackage

// File: rtl/csr_class_decode.sv
// Module: csr_class_decode
// Maps a 12-bit CSR address to its predicate class and marks the
// unimplemented performance counters and event selectors.
// Assumes HPM_FIRST <= HPM_LAST <= 31 and PMP_ENTRIES a multiple of 8, at most 64.
module csr_class_decode
    import csr_chk_pkg::*;
#(
    parameter bit RV32        = 1'b1,
    parameter int PMP_ENTRIES = 16,
    parameter int HPM_FIRST   = 3,
    parameter int HPM_LAST    = 31
) (
    input  logic [11:0] addr_i,
    output csr_dec_t    dec_o
);

    localparam int         CFG_REGS = PMP_ENTRIES / 4;
    localparam logic [4:0] HPM_LO   = 5'(HPM_FIRST);
    localparam logic [4:0] HPM_HI   = 5'(HPM_LAST);

    logic [4:0]  low;
    logic [6:0]  blk;
    logic        hpm_idx;
    logic        hi_ucnt;
    logic        hi_mcnt;
    logic        ucnt;
    logic        mcnt;
    logic        mevt;
    logic        pmp_cfg;
    logic        pmp_adr;
    logic [11:0] adr_off;

    assign low     = addr_i[4:0];
    assign blk     = addr_i[11:5];
    assign hpm_idx = (low >= HPM_LO) && (low <= HPM_HI);
    assign adr_off = addr_i - 12'h3B0;

    // The upper-half counter aliases exist only on a 32-bit core.
    generate
        if (RV32) begin : g_hi_half
            assign hi_ucnt = (blk == 7'h64);
            assign hi_mcnt = (blk == 7'h5C);
        end else begin : g_no_hi_half
            assign hi_ucnt = 1'b0;
            assign hi_mcnt = 1'b0;
        end
    endgenerate

    // The low half of the configuration registers is packed differently per width.
    generate
        if (RV32) begin : g_cfg32
            assign pmp_cfg = (addr_i[11:4] == 8'h3A) && (int'(addr_i[3:0]) < CFG_REGS);
        end else begin : g_cfg64
            assign pmp_cfg = (addr_i[11:4] == 8'h3A) && (int'(addr_i[3:0]) < CFG_REGS)
                             && !addr_i[0];
        end
    endgenerate

    // Counter and protection block membership.
    assign ucnt    = ((blk == 7'h60) || hi_ucnt) && ((low <= 5'd2) || hpm_idx);
    assign mcnt    = ((blk == 7'h58) || hi_mcnt) && ((low == 5'd0) || (low == 5'd2) || hpm_idx);
    assign mevt    = (blk == 7'h19) && hpm_idx;
    assign pmp_adr = (addr_i >= 12'h3B0) && (int'(adr_off) < PMP_ENTRIES);

    // Class lookup: block ranges first, then single registers.
    always_comb begin
        dec_o.cls = CLS_NONE;
        dec_o.raz = 1'b0;
        if ((addr_i >= 12'h001) && (addr_i <= 12'h003)) begin
            dec_o.cls = CLS_FP;
        end else if (ucnt) begin
            dec_o.cls = CLS_UCTR;
            dec_o.raz = hpm_idx;
        end else if (mcnt) begin
            dec_o.cls = CLS_MACH;
            dec_o.raz = hpm_idx;
        end else if (mevt) begin
            dec_o.cls = CLS_MACH;
            dec_o.raz = 1'b1;
        end else if (pmp_cfg || pmp_adr) begin
            dec_o.cls = CLS_PMP;
        end else begin
            case (addr_i)
                12'h300, 12'h301, 12'h302, 12'h303, 12'h304, 12'h305, 12'h306,
                12'h340, 12'h341, 12'h342, 12'h343, 12'h344,
                12'hF11, 12'hF12, 12'hF13, 12'hF14:
                    dec_o.cls = CLS_MACH;
                12'h100, 12'h104, 12'h105, 12'h106,
                12'h140, 12'h141, 12'h142, 12'h143, 12'h144, 12'h180:
                    dec_o.cls = CLS_SUP;
                default:
                    dec_o.cls = CLS_NONE;
            endcase
        end
    end

endmodule

// File: rtl/csr_pred_eval.sv
// Module: csr_pred_eval
// Evaluates the existence predicate of the decoded class against the
// feature bits, FPU state and privilege-selected counter-enable mask.
// Assumes the counter index is the low address bits.
module csr_pred_eval
    import csr_chk_pkg::*;
#(
    parameter int CTR_W = 32
) (
    input  csr_dec_t                   dec_i,
    input  logic [$clog2(CTR_W)-1:0]   ctr_idx_i,
    input  logic [1:0]                 priv_i,
    input  logic [1:0]                 fs_i,
    input  logic [CTR_W-1:0]           mcounteren_i,
    input  logic [CTR_W-1:0]           scounteren_i,
    input  logic                       misa_s_i,
    input  logic                       pmp_en_i,
    output logic                       pred_ok_o
);

    logic [CTR_W-1:0] ctr_mask;

    // Select the enable mask that governs the current privilege.
    always_comb begin
        case (priv_i)
            PRIV_U:  ctr_mask = scounteren_i;
            PRIV_S:  ctr_mask = mcounteren_i;
            PRIV_M:  ctr_mask = '1;
            default: ctr_mask = '0;
        endcase
    end

    // Apply the predicate belonging to the class.
    always_comb begin
        case (dec_i.cls)
            CLS_FP:   pred_ok_o = (fs_i != 2'b00);
            CLS_UCTR: pred_ok_o = ctr_mask[ctr_idx_i];
            CLS_MACH: pred_ok_o = 1'b1;
            CLS_SUP:  pred_ok_o = misa_s_i;
            CLS_PMP:  pred_ok_o = pmp_en_i;
            default:  pred_ok_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/csr_priv_gate.sv
// Module: csr_priv_gate
// Address-encoded checks: the minimum privilege held in bits [9:8] and the
// read-only space marked by bits [11:10].
// Assumes the reserved privilege code never grants access.
module csr_priv_gate
    import csr_chk_pkg::*;
(
    input  logic [11:0] addr_i,
    input  logic [1:0]  priv_i,
    input  logic        wr_i,
    output logic        gate_ok_o
);

    logic priv_low;
    logic ro_write;

    // Privilege too low for the address, or code reserved.
    assign priv_low = (priv_i == PRIV_R) || (priv_i < addr_i[9:8]);

    // Write attempted into the read-only quarter of the space.
    assign ro_write = wr_i && (addr_i[11:10] == 2'b11);

    // Combine both address checks.
    assign gate_ok_o = !priv_low && !ro_write;

endmodule

// File: rtl/csr_legality_check.sv
// Module: csr_legality_check (top)
// Combinational trap decision for one CSR access. Holds no state; outputs
// are valid in the cycle the inputs are presented.
// Assumes the caller samples the outputs after the inputs settle.
module csr_legality_check
    import csr_chk_pkg::*;
#(
    parameter bit RV32        = 1'b1,
    parameter int PMP_ENTRIES = 16,
    parameter int HPM_FIRST   = 3,
    parameter int HPM_LAST    = 31,
    parameter int CTR_W       = 32
) (
    input  logic [11:0]      csr_addr_i,
    input  logic [1:0]       priv_i,
    input  logic             wr_i,
    input  logic [1:0]       fs_i,
    input  logic [CTR_W-1:0] mcounteren_i,
    input  logic [CTR_W-1:0] scounteren_i,
    input  logic             misa_s_i,
    input  logic             pmp_en_i,
    output logic             illegal_o,
    output logic             raz_o
);

    localparam int IDX_W = $clog2(CTR_W);

    csr_dec_t dec;
    logic     pred_ok;
    logic     gate_ok;

    csr_class_decode #(
        .RV32        (RV32),
        .PMP_ENTRIES (PMP_ENTRIES),
        .HPM_FIRST   (HPM_FIRST),
        .HPM_LAST    (HPM_LAST)
    ) u_decode (
        .addr_i (csr_addr_i),
        .dec_o  (dec)
    );

    csr_pred_eval #(
        .CTR_W (CTR_W)
    ) u_pred (
        .dec_i        (dec),
        .ctr_idx_i    (csr_addr_i[IDX_W-1:0]),
        .priv_i       (priv_i),
        .fs_i         (fs_i),
        .mcounteren_i (mcounteren_i),
        .scounteren_i (scounteren_i),
        .misa_s_i     (misa_s_i),
        .pmp_en_i     (pmp_en_i),
        .pred_ok_o    (pred_ok)
    );

    csr_priv_gate u_gate (
        .addr_i    (csr_addr_i),
        .priv_i    (priv_i),
        .wr_i      (wr_i),
        .gate_ok_o (gate_ok)
    );

    // Final decision: both the predicate and the address gate must pass.
    assign illegal_o = !(pred_ok && gate_ok);

    // Zero-read marker only for accesses that will actually complete.
    assign raz_o = dec.raz && !illegal_o;

endmodule

// File: rtl/csr_legality_check_sva.sv
// Module: csr_legality_check_sva
// Checker bound to csr_legality_check. The block has no clock, so the
// checks are immediate assertions evaluated on settled inputs.
module csr_legality_check_sva #(
    parameter int CTR_W = 32
) (
    input logic [11:0]      csr_addr_i,
    input logic [1:0]       priv_i,
    input logic             wr_i,
    input logic [1:0]       fs_i,
    input logic [CTR_W-1:0] mcounteren_i,
    input logic [CTR_W-1:0] scounteren_i,
    input logic             misa_s_i,
    input logic             pmp_en_i,
    input logic             illegal_o,
    input logic             raz_o
);

    logic is_fp;
    logic is_sup;
    logic is_pmp;
    logic is_ucnt;

    assign is_fp   = (csr_addr_i >= 12'h001) && (csr_addr_i <= 12'h003);
    assign is_sup  = (csr_addr_i == 12'h100) || (csr_addr_i == 12'h180) ||
                     ((csr_addr_i >= 12'h104) && (csr_addr_i <= 12'h106)) ||
                     ((csr_addr_i >= 12'h140) && (csr_addr_i <= 12'h144));
    assign is_pmp  = (csr_addr_i >= 12'h3B0) && (csr_addr_i <= 12'h3BF);
    assign is_ucnt = (csr_addr_i[11:5] == 7'h60);

    // Property checks on the combinational outputs.
    always_comb begin
        if (is_fp && (fs_i == 2'b00))
            p_fp_off_r1: assert (illegal_o);
        if (is_ucnt && (priv_i == 2'b00) && !scounteren_i[csr_addr_i[4:0]])
            p_ctr_mask_r2: assert (illegal_o);
        if (is_sup && !misa_s_i)
            p_no_smode_r3: assert (illegal_o);
        if (is_pmp && !pmp_en_i)
            p_no_pmp_r4: assert (illegal_o);
        if ((csr_addr_i == 12'h300) && (priv_i == 2'b11))
            p_mach_pass_r5: assert (!illegal_o);
        if (csr_addr_i == 12'hB01)
            p_unmapped_r6: assert (illegal_o);
        if (priv_i < csr_addr_i[9:8])
            p_min_priv_r7: assert (illegal_o);
        if (wr_i && (csr_addr_i[11:10] == 2'b11))
            p_ro_write_r8: assert (illegal_o);
        p_raz_excl_r9: assert (!(raz_o && illegal_o));
        if (priv_i == 2'b10)
            p_rsvd_priv_r11: assert (illegal_o);
    end

endmodule

bind csr_legality_check csr_legality_check_sva #(.CTR_W(CTR_W)) u_sva (
    .csr_addr_i   (csr_addr_i),
    .priv_i       (priv_i),
    .wr_i         (wr_i),
    .fs_i         (fs_i),
    .mcounteren_i (mcounteren_i),
    .scounteren_i (scounteren_i),
    .misa_s_i     (misa_s_i),
    .pmp_en_i     (pmp_en_i),
    .illegal_o    (illegal_o),
    .raz_o        (raz_o)
);

// File: tb/csr_legality_check_tb_top.sv
// Bench: exhaustive address sweep over U/S/M, both access kinds and four
// feature settings, compared against a model computed from the requirements.
module csr_legality_check_tb_top;

    logic        clk = 1'b0;
    logic [11:0] addr;
    logic [1:0]  priv;
    logic        wr;
    logic [1:0]  fs;
    logic [31:0] mcen;
    logic [31:0] scen;
    logic        ms;
    logic        pe;
    logic        ill;
    logic        raz;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    csr_legality_check dut_i (
        .csr_addr_i   (addr),
        .priv_i       (priv),
        .wr_i         (wr),
        .fs_i         (fs),
        .mcounteren_i (mcen),
        .scounteren_i (scen),
        .misa_s_i     (ms),
        .pmp_en_i     (pe),
        .illegal_o    (ill),
        .raz_o        (raz)
    );

    // 125 MHz clock paces the watchdog.
    always #4 clk = ~clk;

    // Watchdog: a hung run counts as one failure and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: R10 run did not finish, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    // Reference model built from the requirement text.
    function automatic void model(input int a, input int p, input bit w, input bit [1:0] f,
                                  input bit [31:0] mc, input bit [31:0] sc,
                                  input bit s_ok, input bit pmp_ok,
                                  output bit e_ill, output bit e_raz, output string tag);
        int  lo;
        bit  fp, uc, mctr, mev, mach, sup, pmp, pred, hpm;
        lo   = a % 32;
        hpm  = (lo >= 3);
        fp   = (a >= 1 && a <= 3);
        uc   = (a >= 'hC00 && a <= 'hC1F) || (a >= 'hC80 && a <= 'hC9F);
        mctr = ((a >= 'hB00 && a <= 'hB1F) || (a >= 'hB80 && a <= 'hB9F)) && lo != 1;
        mev  = (a >= 'h323 && a <= 'h33F);
        mach = mctr || mev || (a >= 'h300 && a <= 'h306) || (a >= 'h340 && a <= 'h344)
               || (a >= 'hF11 && a <= 'hF14);
        sup  = (a == 'h100) || (a >= 'h104 && a <= 'h106) || (a >= 'h140 && a <= 'h144)
               || (a == 'h180);
        pmp  = (a >= 'h3A0 && a <= 'h3A3) || (a >= 'h3B0 && a <= 'h3BF);
        tag  = "R6";
        pred = 1'b0;
        if (fp) begin
            tag = "R1"; pred = (f != 2'b00);
        end else if (uc) begin
            tag = "R2";
            if (p == 3) pred = 1'b1;
            else if (p == 1) pred = mc[lo];
            else if (p == 0) pred = sc[lo];
        end else if (mach) begin
            tag = "R5"; pred = 1'b1;
        end else if (sup) begin
            tag = "R3"; pred = s_ok;
        end else if (pmp) begin
            tag = "R4"; pred = pmp_ok;
        end
        e_ill = !pred || (p == 2) || (p < ((a / 256) % 4)) || (w && (a / 1024) == 3);
        e_raz = !e_ill && (((mctr || uc) && hpm) || mev);
        if (p < ((a / 256) % 4)) tag = {tag, "/R7"};
        if (w && (a / 1024) == 3) tag = {tag, "/R8"};
        if (e_raz) tag = {tag, "/R9"};
    endfunction

    // Compare both outputs against expectations; one check per call.
    task automatic check(input string req, input bit e_ill, input bit e_raz);
        n_chk = n_chk + 1;
        if (ill !== e_ill || raz !== e_raz) begin
            n_fail = n_fail + 1;
            $display("FAIL %s addr=%h priv=%0d wr=%0b: actual ill=%0b raz=%0b expected ill=%0b raz=%0b",
                     req, addr, priv, wr, ill, raz, e_ill, e_raz);
        end
    endtask

    // Apply a vector, wait for the outputs to settle, then check against the model.
    task automatic apply_model(input int a, input int p, input bit w);
        bit    e_ill, e_raz;
        string tag;
        addr = 12'(a);
        priv = 2'(p);
        wr   = w;
        #2;
        model(a, p, w, fs, mcen, scen, ms, pe, e_ill, e_raz, tag);
        check(tag, e_ill, e_raz);
    endtask

    task automatic set_cfg(input bit [1:0] f, input bit [31:0] mc, input bit [31:0] sc,
                           input bit s_ok, input bit pmp_ok);
        fs = f; mcen = mc; scen = sc; ms = s_ok; pe = pmp_ok;
    endtask

    initial begin
        set_cfg(2'b00, 32'h0, 32'h0, 1'b0, 1'b0);
        addr = 12'h000; priv = 2'b11; wr = 1'b0;
        #2;
        // Idle input state: address 0 is unmapped (R6).
        check("R6 idle", 1'b1, 1'b0);

        // Directed corner cases.
        set_cfg(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1);
        addr = 12'h300; priv = 2'b00; wr = 1'b0; #2;
        check("R7 mstatus from U", 1'b1, 1'b0);
        addr = 12'hC00; priv = 2'b11; wr = 1'b1; #2;
        check("R8 write cycle", 1'b1, 1'b0);
        wr = 1'b0; #2;
        check("R8 read cycle", 1'b0, 1'b0);
        addr = 12'hB03; wr = 1'b1; #2;
        check("R9 mhpmcounter3", 1'b0, 1'b1);
        addr = 12'hB01; #2;
        check("R6 hole at B01", 1'b1, 1'b0);
        addr = 12'h001; priv = 2'b00; wr = 1'b0; fs = 2'b00; #2;
        check("R1 fflags fs off", 1'b1, 1'b0);
        fs = 2'b11; #0;
        #1;
        check("R10 same-step response", 1'b0, 1'b0);
        addr = 12'hC05; priv = 2'b00; scen = 32'hFFFF_FFDF; mcen = 32'h0000_0020; #2;
        check("R2 U uses scounteren", 1'b1, 1'b0);
        priv = 2'b01; #2;
        check("R2 S uses mcounteren", 1'b0, 1'b1);
        addr = 12'h000; priv = 2'b10; #2;
        check("R11 reserved priv", 1'b1, 1'b0);
        addr = 12'h001; #2;
        check("R11 reserved priv fp", 1'b1, 1'b0);
        addr = 12'h180; priv = 2'b01; ms = 1'b0; #2;
        check("R3 satp no S", 1'b1, 1'b0);
        addr = 12'h3B5; priv = 2'b11; pe = 1'b0; #2;
        check("R4 pmpaddr no PMP", 1'b1, 1'b0);

        // Exhaustive sweeps over four feature settings.
        for (int c = 0; c < 4; c++) begin
            case (c)
                0: set_cfg(2'b00, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0);
                1: set_cfg(2'b11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1);
                2: set_cfg(2'b01, 32'hA5A5_0F0F, 32'h5A5A_F0F0, 1'b1, 1'b0);
                default: set_cfg(2'b10, 32'h0000_0005, 32'hFFFF_FFFA, 1'b0, 1'b1);
            endcase
            for (int a = 0; a < 4096; a++) begin
                for (int p = 0; p < 4; p++) begin
                    if (p != 2) begin
                        apply_model(a, p, 1'b0);
                        apply_model(a, p, 1'b1);
                    end
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule